// File: doc/BRIEF.md
# Root Contention Resolver

When two neighbouring nodes each ask the other to become its parent during tree formation, neither request can succeed. This block breaks that tie for one node. When the node's tree logic raises `start_i`, the block takes one random bit and uses it to pick a wait of either `FAST_CYCLES` or `SLOW_CYCLES` clock cycles. While the wait runs, the block holds the node's outgoing parent request on the contended port low. In the last cycle of the wait it samples the neighbour's request line.

If the neighbour is still requesting at that moment, the block pulses `resolve_root_o` and this node takes the root role. If the line is quiet, the block pulses `resend_o` and the tree logic sends its own parent request again. The two nodes may then collide once more, so the block accepts a fresh start as soon as the outcome pulse appears.

The random bit comes either from the `ext_rand_i` pin or from an internal 16-bit maximal-length LFSR. The LFSR advances every clock cycle and its low bit is mixed with `ext_rand_i`. A parameter chooses between the two sources at elaboration.

Top module: `root_contention_resolver`

## Requirements
- R1: After reset, `busy_o`, `resolve_root_o` and `resend_o` are all 0.
- R2: A start accepted at a clock edge samples the random bit at that same edge. A bit of 1 makes `busy_o` stay high for exactly `SLOW_CYCLES` cycles, and a bit of 0 for exactly `FAST_CYCLES` cycles. `SLOW_CYCLES` must be greater than `FAST_CYCLES`, and `FAST_CYCLES` must be at least 1.
- R3: `tx_req_o` is 0 whenever `busy_o` is 1. When the block is idle, `tx_req_o` equals `req_drive_i`.
- R4: If `line_req_i` is 1 at the edge that ends the wait, `resolve_root_o` is 1 for the single cycle that follows.
- R5: If `line_req_i` is 0 at the edge that ends the wait, `resend_o` is 1 for the single cycle that follows.
- R6: Each accepted start produces exactly one outcome pulse, one cycle wide, and `resolve_root_o` and `resend_o` are never high together.
- R7: A start raised while `busy_o` is 1 is ignored. The running wait keeps its length, and no extra round follows.
- R8: A start raised in the cycle in which the outcome pulse is visible is accepted as a new round.
- R9: The value of `line_req_i` before the last cycle of the wait has no effect on the outcome.
- R10: With `RAND_SRC` set to the internal source, the random bit is the low bit of a 16-bit maximal-length LFSR that steps every cycle, XORed with `ext_rand_i`. Across repeated rounds, both wait lengths occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a contention round (ignored while busy) |
| ext_rand_i | input | 1 | External random bit, or a mixing bit when the internal source is used |
| line_req_i | input | 1 | Sampled state of the neighbour's incoming parent request |
| req_drive_i | input | 1 | Outgoing parent request from the node's tree logic |
| tx_req_o | output | 1 | Outgoing parent request after gating (held low during a wait) |
| busy_o | output | 1 | Wait in progress |
| resolve_root_o | output | 1 | One-cycle pulse: this node becomes root |
| resend_o | output | 1 | One-cycle pulse: resend own parent request |

## Verification
The bench drives rounds with each random value and each final line state. In every round it holds the neighbour line at the opposite value until the last wait cycle. A design that samples the line early, or latches it once, therefore reports the wrong outcome. It also measures each wait length, which catches swapped or off-by-one durations. A stray start injected mid-wait would show up as a stretched wait or an unexpected extra pulse. Back-to-back rounds, with the new start placed in the pulse cycle, catch a block that only returns to idle one cycle late. A run on the internal LFSR source must show both wait lengths.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

   typedef enum logic {
      SRC_EXTERNAL = 1'b0,
      SRC_INTERNAL = 1'b1
   } rand_src_e;

   // One step of a right-shifting Galois LFSR
   function automatic logic [15:0] lfsr_step(input logic [15:0] s, input logic [15:0] taps);
      lfsr_step = s[0] ? ((s >> 1) ^ taps) : (s >> 1);
   endfunction

endpackage

// File: rtl/rcr_lfsr.sv
module rcr_lfsr #(
   parameter logic [15:0] TAPS = 16'hB400,
   parameter logic [15:0] SEED = 16'hACE1
) (
   input  logic clk,
   input  logic rst_n,
   output logic bit_o
);
   logic [15:0] state_q;

   if (SEED == 16'h0) begin : g_bad_seed
      $error("rcr_lfsr: SEED must be nonzero");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEED;
      else        state_q <= rcr_pkg::lfsr_step(state_q, TAPS);
   end

   assign bit_o = state_q[0];
endmodule

// File: rtl/rcr_wait_timer.sv
module rcr_wait_timer #(
   parameter int FAST_CYCLES = 16,
   parameter int SLOW_CYCLES = 48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic slow_i,
   output logic busy_o,
   output logic expire_o
);
   localparam int CW = $clog2(SLOW_CYCLES + 1);
   localparam logic [CW-1:0] FAST_LOAD = CW'(FAST_CYCLES - 1);
   localparam logic [CW-1:0] SLOW_LOAD = CW'(SLOW_CYCLES - 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         if (load_i) begin
            busy_q <= 1'b1;
            cnt_q  <= slow_i ? SLOW_LOAD : FAST_LOAD;
         end
      end else if (cnt_q == '0) begin
         busy_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o   = busy_q;
   assign expire_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/root_contention_resolver.sv
module root_contention_resolver #(
   parameter int                  FAST_CYCLES = 16,
   parameter int                  SLOW_CYCLES = 48,
   parameter rcr_pkg::rand_src_e  RAND_SRC    = rcr_pkg::SRC_INTERNAL,
   parameter logic [15:0]         LFSR_TAPS   = 16'hB400,
   parameter logic [15:0]         LFSR_SEED   = 16'hACE1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic ext_rand_i,
   input  logic line_req_i,
   input  logic req_drive_i,
   output logic tx_req_o,
   output logic busy_o,
   output logic resolve_root_o,
   output logic resend_o
);
   if (FAST_CYCLES < 1) begin : g_bad_fast
      $error("root_contention_resolver: FAST_CYCLES must be at least 1");
   end
   if (SLOW_CYCLES <= FAST_CYCLES) begin : g_bad_slow
      $error("root_contention_resolver: SLOW_CYCLES must exceed FAST_CYCLES");
   end

   logic rand_bit;
   logic busy;
   logic expire;
   logic accept;
   logic root_q;
   logic resend_q;

   if (RAND_SRC == rcr_pkg::SRC_INTERNAL) begin : g_int_rand
      logic lfsr_bit;
      rcr_lfsr #(.TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
         .clk   (clk),
         .rst_n (rst_n),
         .bit_o (lfsr_bit)
      );
      assign rand_bit = lfsr_bit ^ ext_rand_i;
   end else begin : g_ext_rand
      assign rand_bit = ext_rand_i;
   end

   assign accept = start_i && !busy;

   rcr_wait_timer #(.FAST_CYCLES(FAST_CYCLES), .SLOW_CYCLES(SLOW_CYCLES)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (accept),
      .slow_i   (rand_bit),
      .busy_o   (busy),
      .expire_o (expire)
   );

   // Outcome is decided only at the last wait edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         root_q   <= 1'b0;
         resend_q <= 1'b0;
      end else begin
         root_q   <= expire &&  line_req_i;
         resend_q <= expire && !line_req_i;
      end
   end

   assign busy_o         = busy;
   assign tx_req_o       = req_drive_i && !busy;
   assign resolve_root_o = root_q;
   assign resend_o       = resend_q;
endmodule

// File: rtl/rcr_checker.sv
module rcr_checker #(
   parameter int FAST_CYCLES = 16,
   parameter int SLOW_CYCLES = 48
) (
   input logic clk,
   input logic rst_n,
   input logic line_req_i,
   input logic tx_req_o,
   input logic busy_o,
   input logic resolve_root_o,
   input logic resend_o
);
   localparam int LW = $clog2(SLOW_CYCLES + 2);
   logic [LW-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          run_len <= '0;
      else if (!busy_o)                    run_len <= '0;
      else if (run_len != LW'(SLOW_CYCLES + 1)) run_len <= run_len + 1'b1;
   end

   AST_WAIT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (run_len == LW'(FAST_CYCLES) || run_len == LW'(SLOW_CYCLES))); // R2
   AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !tx_req_o); // R3
   AST_ROOT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      resolve_root_o |-> $past(line_req_i)); // R4
   AST_RESEND_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      resend_o |-> !$past(line_req_i)); // R5
   AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(resolve_root_o && resend_o)); // R6
   AST_PULSE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      (resolve_root_o || resend_o) |-> $fell(busy_o)); // R6
   AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (resolve_root_o || resend_o) |=> !(resolve_root_o || resend_o)); // R6
endmodule

bind root_contention_resolver rcr_checker #(
   .FAST_CYCLES (FAST_CYCLES),
   .SLOW_CYCLES (SLOW_CYCLES)
) u_rcr_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .line_req_i     (line_req_i),
   .tx_req_o       (tx_req_o),
   .busy_o         (busy_o),
   .resolve_root_o (resolve_root_o),
   .resend_o       (resend_o)
);

// File: tb/root_contention_resolver_bench.sv
module root_contention_resolver_bench;
   localparam int FAST = 4;
   localparam int SLOW = 9;

   typedef struct {
      bit root;
      int len;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, rbit = 1'b0, line = 1'b0, drive = 1'b0;
   logic tx, busy, root, resend;
   logic start2 = 1'b0;
   logic tx2, busy2, root2, resend2;

   int n_chk = 0, n_bad = 0;
   exp_t q[$];
   int len1 = 0, len2 = 0, rounds2 = 0;
   bit seen_fast = 0, seen_slow = 0, prev_pulse = 0;

   always #10 clk = ~clk;

   root_contention_resolver #(.FAST_CYCLES(FAST), .SLOW_CYCLES(SLOW),
      .RAND_SRC(rcr_pkg::SRC_EXTERNAL)) u_root_contention_resolver (
      .clk(clk), .rst_n(rst_n), .start_i(start), .ext_rand_i(rbit),
      .line_req_i(line), .req_drive_i(drive), .tx_req_o(tx), .busy_o(busy),
      .resolve_root_o(root), .resend_o(resend));

   root_contention_resolver #(.FAST_CYCLES(FAST), .SLOW_CYCLES(SLOW),
      .RAND_SRC(rcr_pkg::SRC_INTERNAL)) u_lfsr_variant (
      .clk(clk), .rst_n(rst_n), .start_i(start2), .ext_rand_i(1'b0),
      .line_req_i(1'b0), .req_drive_i(1'b0), .tx_req_o(tx2), .busy_o(busy2),
      .resolve_root_o(root2), .resend_o(resend2));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Driver: one contention round, pushes the expected outcome
   task automatic run_round(input bit rb, input bit line_end, input bit stray);
      int n;
      exp_t e;
      n = rb ? SLOW : FAST;
      e.root = line_end;
      e.len = n;
      @(negedge clk);
      start = 1'b1; rbit = rb; line = ~line_end; drive = 1'b1;
      q.push_back(e);
      @(negedge clk);
      start = stray; rbit = ~rb;
      #1 check(tx == 1'b0, "R3 tx held low while busy", tx, 0);
      for (int k = 2; k <= n; k++) begin
         @(negedge clk);
         start = 1'b0;
         if (k == n) line = line_end;
      end
      drive = 1'b0;
   endtask

   // Monitor / scoreboard for the external-source instance
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy) len1++;
         if (root && resend) check(0, "R6 both pulses", 1, 0);
         if (prev_pulse && (root || resend)) check(0, "R6 pulse wider than one cycle", 2, 1);
         if (root || resend) begin
            if (q.size() == 0) begin
               check(0, "R7 R6 unexpected extra outcome", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(root == e.root, "R4 R5 R9 outcome (root=1)", root, e.root);
               check(len1 == e.len, "R2 R7 wait length", len1, e.len);
            end
            len1 = 0;
         end
         prev_pulse = root || resend;
      end
   end

   // Monitor for the internal LFSR instance
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy2) len2++;
         if (resend2) begin
            check(len2 == FAST || len2 == SLOW, "R10 LFSR wait length", len2, FAST);
            if (len2 == FAST) seen_fast = 1;
            if (len2 == SLOW) seen_slow = 1;
            len2 = 0;
            rounds2++;
         end
      end
   end

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 0, "R1 busy after reset", busy, 0);
      check(root == 0, "R1 root after reset", root, 0);
      check(resend == 0, "R1 resend after reset", resend, 0);
      drive = 1'b1;
      #1 check(tx == 1'b1, "R3 tx follows drive when idle", tx, 1);
      drive = 1'b0;

      run_round(1'b0, 1'b1, 1'b0);   // fast, root
      run_round(1'b1, 1'b0, 1'b0);   // slow, resend
      repeat (3) @(negedge clk);
      run_round(1'b1, 1'b1, 1'b1);   // stray start mid-wait
      repeat (2) @(negedge clk);
      run_round(1'b0, 1'b0, 1'b0);   // resend then
      run_round(1'b1, 1'b1, 1'b0);   // R8 start in pulse cycle
      run_round(1'b0, 1'b0, 1'b1);   // fast with stray
      repeat (4) @(negedge clk);
      check(q.size() == 0, "R6 R8 every round produced an outcome", q.size(), 0);
      check(busy == 0, "R7 idle after rounds", busy, 0);
      drive = 1'b1;
      #1 check(tx == 1'b1, "R3 tx follows drive after rounds", tx, 1);
      drive = 1'b0;

      for (int i = 0; i < 24; i++) begin
         @(negedge clk);
         start2 = 1'b1;
         @(negedge clk);
         start2 = 1'b0;
         while (!resend2) @(negedge clk);
         repeat (i % 5) @(negedge clk);
      end
      repeat (2) @(negedge clk);
      check(rounds2 == 24, "R10 rounds completed", rounds2, 24);
      check(seen_fast && seen_slow, "R10 both lengths seen", {seen_fast, seen_slow}, 3);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule